// File: doc/BRIEF.md
# Cascadable Address-Routing Bus Node

This block is one node of a daisy chain of routers on a Wishbone-style bus. A single master-side (upstream) port feeds it bus cycles. For each cycle the node inspects the address. If the two top address bits equal the node's fixed prefix parameter and address bits [15:12] equal its 4-bit node identity input, the cycle goes to the node's local I/O port. Any other cycle is passed unchanged to the downstream port, where the next node in the chain can decode it. Read data, acknowledge and error come back to the master only from the side that was chosen.

Requests are forwarded without added wait states. A small state machine records which side a cycle went to. It has three states. In `RN_IDLE` no cycle is held and the route follows the live address decode. In `RN_LOCAL` a cycle owns the local port, and in `RN_NEXT` a cycle owns the downstream port. The named transitions are as follows. *grab_local* and *grab_next* go from `RN_IDLE` to a route state when a request starts and is not answered in the same cycle. *finish* returns to `RN_IDLE` on acknowledge or error from the owned side. *abort* returns to `RN_IDLE` when the master drops cycle. *instant* keeps `RN_IDLE` when the response arrives in the same cycle as the request. A synchronous reset forces `RN_IDLE`.

Top module: `chain_route_node`

## Requirements
- R1: A request (cycle and strobe high) whose address bits [31:30] equal PREFIX and bits [15:12] equal node_id is driven onto the local port's strobe and cycle in the same clock cycle.
- R2: A request that fails either comparison (wrong prefix or a different ID) is driven onto the downstream port in the same cycle, with address, write data, write enable and byte select identical to the upstream values.
- R3: Address, write data, write enable and byte select reach the selected port unchanged. The unselected port sees strobe, cycle, write enable and byte select all 0.
- R4: The local and downstream cycle outputs are never both high.
- R5: The route is fixed in the first cycle in which cycle and strobe are high. It holds until the owned side returns acknowledge or error, or until cycle drops, even if the address changes in the meantime.
- R6: Upstream read data, acknowledge and error come only from the side that owns the current cycle. Acknowledge or error from the other side has no effect.
- R7: While the synchronous active-high reset is high, all output strobes and cycles are 0, and reset clears a held route.
- R8: A response in the same cycle as the request ends that cycle. In the next cycle the route again follows the live address.
- R9: Dropping upstream cycle while a route is held releases the route. The next request is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | 4 | Identity of this node in the chain |
| up_adr | input | ADR_W | Upstream address |
| up_wdat | input | DAT_W | Upstream write data |
| up_we | input | 1 | Upstream write enable (1 = write) |
| up_sel | input | SEL_W | Upstream byte select |
| up_stb | input | 1 | Upstream strobe |
| up_cyc | input | 1 | Upstream cycle |
| up_rdat | output | DAT_W | Read data to master |
| up_ack | output | 1 | Acknowledge to master |
| up_err | output | 1 | Error to master |
| io_adr | output | ADR_W | Local port address |
| io_wdat | output | DAT_W | Local port write data |
| io_we | output | 1 | Local port write enable |
| io_sel | output | SEL_W | Local port byte select |
| io_stb | output | 1 | Local port strobe |
| io_cyc | output | 1 | Local port cycle |
| io_rdat | input | DAT_W | Local port read data |
| io_ack | input | 1 | Local port acknowledge |
| io_err | input | 1 | Local port error |
| dn_adr | output | ADR_W | Downstream address |
| dn_wdat | output | DAT_W | Downstream write data |
| dn_we | output | 1 | Downstream write enable |
| dn_sel | output | SEL_W | Downstream byte select |
| dn_stb | output | 1 | Downstream strobe |
| dn_cyc | output | 1 | Downstream cycle |
| dn_rdat | input | DAT_W | Downstream read data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_err | input | 1 | Downstream error |

## Verification
Route holding and response selection can fall in the same cycle. While the local port owns a cycle, the bench moves the upstream address to a downstream target and raises the downstream acknowledge in that same cycle. The check is that the strobe stays on the local port and the master sees no acknowledge; a route that followed the live address would let the stray acknowledge through. A second collision is covered by the zero-wait case. There the response and the request share one cycle, and a local hit presented in the next cycle must go out at once rather than wait on a stale route.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        RN_IDLE  = 2'd0,
        RN_LOCAL = 2'd1,
        RN_NEXT  = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_decode.sv
module rn_decode #(
    parameter int         ADR_W  = 32,
    parameter int         ID_W   = 4,
    parameter int         ID_LSB = 12,
    parameter logic [1:0] PREFIX = 2'b10
) (
    input  logic [ADR_W-1:0] adr,
    input  logic [ID_W-1:0]  node_id,
    output logic             hit
);
    localparam int PFX_LSB = ADR_W - 2;

    logic pfx_ok;
    logic id_ok;

    always_comb begin
        pfx_ok = (adr[PFX_LSB +: 2] == PREFIX);
        id_ok  = (adr[ID_LSB +: ID_W] == node_id);
        hit    = pfx_ok && id_ok;
    end
endmodule

// File: rtl/rn_route_fsm.sv
module rn_route_fsm
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    input  logic hit,
    input  logic done_local,
    input  logic done_next,
    output logic route_local
);
    rn_state_e state_q;
    rn_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RN_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RN_IDLE: begin
                if (cyc && stb) begin
                    if (hit) state_d = done_local ? RN_IDLE : RN_LOCAL;
                    else     state_d = done_next  ? RN_IDLE : RN_NEXT;
                end
            end
            RN_LOCAL: if (!cyc || done_local) state_d = RN_IDLE;
            RN_NEXT:  if (!cyc || done_next)  state_d = RN_IDLE;
            default:  state_d = RN_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RN_IDLE:  route_local = hit;
            RN_LOCAL: route_local = 1'b1;
            RN_NEXT:  route_local = 1'b0;
            default:  route_local = 1'b0;
        endcase
    end

    // R7
    reset_idle_chk: assert property (@(posedge clk) rst |=> state_q == RN_IDLE);
endmodule

// File: rtl/rn_resp_mux.sv
module rn_resp_mux #(
    parameter int DAT_W = 32
) (
    input  logic             en,
    input  logic             route_local,
    input  logic [DAT_W-1:0] io_rdat,
    input  logic             io_ack,
    input  logic             io_err,
    input  logic [DAT_W-1:0] dn_rdat,
    input  logic             dn_ack,
    input  logic             dn_err,
    output logic [DAT_W-1:0] up_rdat,
    output logic             up_ack,
    output logic             up_err
);
    always_comb begin
        up_rdat = route_local ? io_rdat : dn_rdat;
        up_ack  = en && (route_local ? io_ack : dn_ack);
        up_err  = en && (route_local ? io_err : dn_err);
    end
endmodule

// File: rtl/chain_route_node.sv
module chain_route_node #(
    parameter int         ADR_W  = 32,
    parameter int         DAT_W  = 32,
    parameter int         SEL_W  = DAT_W / 8,
    parameter int         ID_W   = 4,
    parameter int         ID_LSB = 12,
    parameter logic [1:0] PREFIX = 2'b10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ID_W-1:0]  node_id,
    input  logic [ADR_W-1:0] up_adr,
    input  logic [DAT_W-1:0] up_wdat,
    input  logic             up_we,
    input  logic [SEL_W-1:0] up_sel,
    input  logic             up_stb,
    input  logic             up_cyc,
    output logic [DAT_W-1:0] up_rdat,
    output logic             up_ack,
    output logic             up_err,
    output logic [ADR_W-1:0] io_adr,
    output logic [DAT_W-1:0] io_wdat,
    output logic             io_we,
    output logic [SEL_W-1:0] io_sel,
    output logic             io_stb,
    output logic             io_cyc,
    input  logic [DAT_W-1:0] io_rdat,
    input  logic             io_ack,
    input  logic             io_err,
    output logic [ADR_W-1:0] dn_adr,
    output logic [DAT_W-1:0] dn_wdat,
    output logic             dn_we,
    output logic [SEL_W-1:0] dn_sel,
    output logic             dn_stb,
    output logic             dn_cyc,
    input  logic [DAT_W-1:0] dn_rdat,
    input  logic             dn_ack,
    input  logic             dn_err
);
    logic hit;
    logic route_local;
    logic en;
    logic go_io;
    logic go_dn;

    assign en = !rst && up_cyc;

    rn_decode #(
        .ADR_W (ADR_W),
        .ID_W  (ID_W),
        .ID_LSB(ID_LSB),
        .PREFIX(PREFIX)
    ) u_decode (
        .adr    (up_adr),
        .node_id(node_id),
        .hit    (hit)
    );

    rn_route_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cyc        (up_cyc),
        .stb        (up_stb),
        .hit        (hit),
        .done_local (io_ack || io_err),
        .done_next  (dn_ack || dn_err),
        .route_local(route_local)
    );

    rn_resp_mux #(.DAT_W(DAT_W)) u_resp (
        .en         (en),
        .route_local(route_local),
        .io_rdat    (io_rdat),
        .io_ack     (io_ack),
        .io_err     (io_err),
        .dn_rdat    (dn_rdat),
        .dn_ack     (dn_ack),
        .dn_err     (dn_err),
        .up_rdat    (up_rdat),
        .up_ack     (up_ack),
        .up_err     (up_err)
    );

    always_comb begin
        go_io   = en && route_local;
        go_dn   = en && !route_local;
        io_adr  = up_adr;
        io_wdat = up_wdat;
        io_we   = go_io && up_we;
        io_sel  = go_io ? up_sel : '0;
        io_stb  = go_io && up_stb;
        io_cyc  = go_io;
        dn_adr  = up_adr;
        dn_wdat = up_wdat;
        dn_we   = go_dn && up_we;
        dn_sel  = go_dn ? up_sel : '0;
        dn_stb  = go_dn && up_stb;
        dn_cyc  = go_dn;
    end

    // R4
    one_path_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_cyc && dn_cyc));

    // R5
    hold_route_chk: assert property (@(posedge clk) disable iff (rst)
        (io_stb && !io_ack && !io_err) |=> (!dn_stb));

    // R6
    ignore_other_chk: assert property (@(posedge clk) disable iff (rst)
        (io_cyc && !io_ack) |-> !up_ack);

    // R3
    pass_fields_chk: assert property (@(posedge clk) disable iff (rst)
        dn_stb |-> (dn_adr == up_adr && dn_sel == up_sel && dn_we == up_we));
endmodule

// File: tb/test_chain_route_node.sv
module test_chain_route_node;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- single node under direct drive ----------------
    logic [3:0]    nid;
    logic [AW-1:0] u_adr;
    logic [DW-1:0] u_wdat;
    logic          u_we, u_stb, u_cyc;
    logic [SW-1:0] u_sel;
    logic [DW-1:0] u_rdat;
    logic          u_ack, u_err;
    logic [AW-1:0] i_adr, d_adr;
    logic [DW-1:0] i_wdat, d_wdat;
    logic          i_we, i_stb, i_cyc, d_we, d_stb, d_cyc;
    logic [SW-1:0] i_sel, d_sel;
    logic [DW-1:0] i_rdat, d_rdat;
    logic          i_ack, i_err, d_ack, d_err;

    chain_route_node i_chain_route_node (
        .clk(clk), .rst(rst), .node_id(nid),
        .up_adr(u_adr), .up_wdat(u_wdat), .up_we(u_we), .up_sel(u_sel),
        .up_stb(u_stb), .up_cyc(u_cyc),
        .up_rdat(u_rdat), .up_ack(u_ack), .up_err(u_err),
        .io_adr(i_adr), .io_wdat(i_wdat), .io_we(i_we), .io_sel(i_sel),
        .io_stb(i_stb), .io_cyc(i_cyc),
        .io_rdat(i_rdat), .io_ack(i_ack), .io_err(i_err),
        .dn_adr(d_adr), .dn_wdat(d_wdat), .dn_we(d_we), .dn_sel(d_sel),
        .dn_stb(d_stb), .dn_cyc(d_cyc),
        .dn_rdat(d_rdat), .dn_ack(d_ack), .dn_err(d_err)
    );

    // ---------------- chain of three nodes ----------------
    logic [AW-1:0] c_adr [4];
    logic [DW-1:0] c_wdat[4];
    logic          c_we  [4];
    logic [SW-1:0] c_sel [4];
    logic          c_stb [4];
    logic          c_cyc [4];
    logic [DW-1:0] c_rdat[4];
    logic          c_ack [4];
    logic          c_err [4];
    logic [AW-1:0] p_adr [3];
    logic [DW-1:0] p_wdat[3];
    logic          p_we  [3];
    logic [SW-1:0] p_sel [3];
    logic          p_stb [3];
    logic          p_cyc [3];
    logic [DW-1:0] r_rdat[4];
    logic          r_ack [4];
    logic          r_err [4];

    for (genvar k = 0; k < 3; k++) begin : g_chain
        chain_route_node u_node (
            .clk(clk), .rst(rst), .node_id(4'(k)),
            .up_adr(c_adr[k]), .up_wdat(c_wdat[k]), .up_we(c_we[k]), .up_sel(c_sel[k]),
            .up_stb(c_stb[k]), .up_cyc(c_cyc[k]),
            .up_rdat(c_rdat[k]), .up_ack(c_ack[k]), .up_err(c_err[k]),
            .io_adr(p_adr[k]), .io_wdat(p_wdat[k]), .io_we(p_we[k]), .io_sel(p_sel[k]),
            .io_stb(p_stb[k]), .io_cyc(p_cyc[k]),
            .io_rdat(r_rdat[k]), .io_ack(r_ack[k]), .io_err(r_err[k]),
            .dn_adr(c_adr[k+1]), .dn_wdat(c_wdat[k+1]), .dn_we(c_we[k+1]), .dn_sel(c_sel[k+1]),
            .dn_stb(c_stb[k+1]), .dn_cyc(c_cyc[k+1]),
            .dn_rdat(c_rdat[k+1]), .dn_ack(c_ack[k+1]), .dn_err(c_err[k+1])
        );
    end

    assign c_rdat[3] = r_rdat[3];
    assign c_ack[3]  = r_ack[3];
    assign c_err[3]  = r_err[3];

    // responder view: targets 0..2 are the local ports, 3 is the chain end
    logic [AW-1:0] s_adr [4];
    logic [DW-1:0] s_wdat[4];
    logic          s_we  [4];
    logic [SW-1:0] s_sel [4];
    logic          s_stb [4];
    logic          s_cyc [4];
    always_comb begin
        for (int j = 0; j < 3; j++) begin
            s_adr[j] = p_adr[j]; s_wdat[j] = p_wdat[j]; s_we[j] = p_we[j];
            s_sel[j] = p_sel[j]; s_stb[j] = p_stb[j];   s_cyc[j] = p_cyc[j];
        end
        s_adr[3] = c_adr[3]; s_wdat[3] = c_wdat[3]; s_we[3] = c_we[3];
        s_sel[3] = c_sel[3]; s_stb[3] = c_stb[3];   s_cyc[3] = c_cyc[3];
    end

    function automatic logic [31:0] seed(input int j, input int i);
        return {8'(j), 8'hA5, 8'h3C, 8'(i)};
    endfunction

    logic [31:0] smem[4][16];
    always_ff @(posedge clk) begin
        for (int j = 0; j < 4; j++) begin
            if (rst) begin
                r_ack[j] <= 1'b0;
                r_err[j] <= 1'b0;
                for (int i = 0; i < 16; i++) smem[j][i] <= seed(j, i);
            end else begin
                logic go;
                logic bad;
                go  = s_cyc[j] && s_stb[j] && !r_ack[j] && !r_err[j];
                bad = (j == 3) && s_adr[j][8];
                r_ack[j] <= go && !bad;
                r_err[j] <= go && bad;
                if (go && !bad && s_we[j])
                    for (int b = 0; b < 4; b++)
                        if (s_sel[j][b]) smem[j][s_adr[j][5:2]][8*b +: 8] <= s_wdat[j][8*b +: 8];
            end
        end
    end
    always_comb for (int j = 0; j < 4; j++) r_rdat[j] = smem[j][s_adr[j][5:2]];

    // ---------------- behavioural reference ----------------
    logic [31:0] exp_mem[4][16];
    logic        mon_on = 1'b0;

    function automatic int target(input logic [31:0] a);
        if (a[31:30] == 2'b10 && a[15:12] < 4'd3) return int'(a[15:12]);
        return 3;
    endfunction

    function automatic logic [31:0] mk_adr(input logic [1:0] pfx, input logic [3:0] id,
                                           input logic bad, input int w);
        return {pfx, 14'h0, id, 3'b000, bad, 8'(w << 2)};
    endfunction

    // per-clock comparison of which responder sees the cycle (R1, R2, R4)
    always @(negedge clk) begin
        #2;
        if (!rst && mon_on) begin
            for (int j = 0; j < 4; j++)
                chk($sformatf("R4 chain path %0d active", j), 32'(s_cyc[j]),
                    32'(c_cyc[0] && (j == target(c_adr[0]))));
        end
    end

    task automatic xfer(input logic [31:0] a, input logic we, input logic [31:0] d,
                        input logic [3:0] sel, output logic [31:0] rd, output logic er);
        @(negedge clk);
        c_adr[0] = a; c_wdat[0] = d; c_we[0] = we; c_sel[0] = sel;
        c_stb[0] = 1'b1; c_cyc[0] = 1'b1;
        do begin
            @(posedge clk); #1;
        end while (!(c_ack[0] || c_err[0]));
        rd = c_rdat[0];
        er = c_err[0];
        @(negedge clk);
        c_stb[0] = 1'b0; c_cyc[0] = 1'b0;
    endtask

    task automatic chain_rw(input string req, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] sel);
        logic [31:0] rd;
        logic        er;
        int          t;
        t = target(a);
        xfer(a, 1'b1, d, sel, rd, er);
        chk({req, " write err"}, 32'(er), 32'(0));
        for (int b = 0; b < 4; b++)
            if (sel[b]) exp_mem[t][a[5:2]][8*b +: 8] = d[8*b +: 8];
        xfer(a, 1'b0, 32'h0, 4'hF, rd, er);
        chk({req, " readback"}, rd, exp_mem[t][a[5:2]]);
    endtask

    task automatic step_drive();
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        nid = 4'd5;
        u_adr = '0; u_wdat = '0; u_we = 0; u_sel = '0; u_stb = 0; u_cyc = 0;
        i_rdat = 32'h1111_1111; i_ack = 0; i_err = 0;
        d_rdat = 32'h2222_2222; d_ack = 0; d_err = 0;
        c_adr[0] = '0; c_wdat[0] = '0; c_we[0] = 0; c_sel[0] = '0; c_stb[0] = 0; c_cyc[0] = 0;
        for (int j = 0; j < 4; j++) for (int i = 0; i < 16; i++) exp_mem[j][i] = seed(j, i);

        // R7: outputs quiet in reset even with a request present
        u_adr = mk_adr(2'b10, 4'd5, 1'b0, 1); u_cyc = 1; u_stb = 1;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R7 io_cyc in reset", 32'(i_cyc), 0);
        chk("R7 dn_cyc in reset", 32'(d_cyc), 0);
        chk("R7 io_stb in reset", 32'(i_stb), 0);
        u_cyc = 0; u_stb = 0;
        rst = 0;

        // R1 / R3: local hit
        step_drive();
        u_adr = mk_adr(2'b10, 4'd5, 1'b0, 3); u_wdat = 32'hCAFE_0001; u_we = 1; u_sel = 4'b0110;
        u_cyc = 1; u_stb = 1;
        #1;
        chk("R1 io_stb on hit", 32'(i_stb), 1);
        chk("R1 dn_stb on hit", 32'(d_stb), 0);
        chk("R3 io_adr", i_adr, u_adr);
        chk("R3 io_wdat", i_wdat, 32'hCAFE_0001);
        chk("R3 io_we", 32'(i_we), 1);
        chk("R3 io_sel", 32'(i_sel), 32'b0110);
        chk("R3 dn_sel idle", 32'(d_sel), 0);
        chk("R3 dn_we idle", 32'(d_we), 0);

        // R5 / R6: address moves to a miss, stray downstream ack in same cycle
        step_drive();
        u_adr = mk_adr(2'b01, 4'd5, 1'b0, 3); d_ack = 1;
        #1;
        chk("R5 route held io_stb", 32'(i_stb), 1);
        chk("R5 route held dn_stb", 32'(d_stb), 0);
        chk("R6 stray ack ignored", 32'(u_ack), 0);
        step_drive();
        d_ack = 0; i_ack = 1; i_rdat = 32'hBEEF_1234;
        #1;
        chk("R6 local ack passed", 32'(u_ack), 1);
        chk("R6 local rdat passed", u_rdat, 32'hBEEF_1234);
        step_drive();
        i_ack = 0;
        #1;
        chk("R5 released dn_stb", 32'(d_stb), 1);
        chk("R2 dn_adr equal", d_adr, u_adr);
        chk("R2 dn_wdat equal", d_wdat, u_wdat);
        chk("R2 io_stb off", 32'(i_stb), 0);
        step_drive();
        d_err = 1;
        #1;
        chk("R6 downstream err passed", 32'(u_err), 1);
        step_drive();
        d_err = 0; u_cyc = 0; u_stb = 0;

        // R2: right prefix, other ID
        step_drive();
        u_adr = mk_adr(2'b10, 4'd6, 1'b0, 0); u_cyc = 1; u_stb = 1; u_we = 0; u_sel = 4'hF;
        #1;
        chk("R2 other id to dn", 32'(d_stb), 1);
        chk("R3 dn_we read", 32'(d_we), 0);

        // R8: zero-wait downstream response, then a hit must go out at once
        d_ack = 1;
        #1;
        chk("R8 same-cycle ack", 32'(u_ack), 1);
        step_drive();
        d_ack = 0; u_adr = mk_adr(2'b10, 4'd5, 1'b0, 0);
        #1;
        chk("R8 next request decoded", 32'(i_stb), 1);

        // R9: abort by dropping cycle, then a miss
        step_drive();
        u_cyc = 0; u_stb = 0;
        #1;
        chk("R9 io_cyc after drop", 32'(i_cyc), 0);
        step_drive();
        u_adr = mk_adr(2'b00, 4'd5, 1'b0, 0); u_cyc = 1; u_stb = 1;
        #1;
        chk("R9 fresh decode to dn", 32'(d_stb), 1);

        // R7: reset clears a held local route
        step_drive();
        u_adr = mk_adr(2'b10, 4'd5, 1'b0, 0); u_cyc = 0; u_stb = 0;
        step_drive();
        u_cyc = 1; u_stb = 1;
        step_drive();
        rst = 1;
        #1;
        chk("R7 io_cyc during reset", 32'(i_cyc), 0);
        step_drive();
        rst = 0; u_adr = mk_adr(2'b11, 4'd5, 1'b0, 0);
        #1;
        chk("R7 route cleared", 32'(d_cyc), 1);
        step_drive();
        u_cyc = 0; u_stb = 0;

        // chain: writes and reads to each local port and past the end
        mon_on = 1'b1;
        for (int id = 0; id < 3; id++)
            chain_rw($sformatf("R1 chain node %0d", id), mk_adr(2'b10, 4'(id), 1'b0, id + 2),
                     32'h5A00_0000 | 32'(id), 4'hF);
        chain_rw("R3 chain byte lanes", mk_adr(2'b10, 4'd1, 1'b0, 7), 32'hA1B2_C3D4, 4'b1001);
        chain_rw("R2 chain wrong prefix", mk_adr(2'b01, 4'd1, 1'b0, 4), 32'h0BAD_F00D, 4'hF);
        chain_rw("R2 chain unknown id", mk_adr(2'b10, 4'd7, 1'b0, 5), 32'h7777_0005, 4'hF);
        xfer(mk_adr(2'b10, 4'd9, 1'b1, 0), 1'b0, 32'h0, 4'hF, rd, er);
        chk("R6 chain end error", 32'(er), 1);
        // the node-2 port kept its own data after the fall-through traffic
        xfer(mk_adr(2'b10, 4'd2, 1'b0, 4), 1'b0, 32'h0, 4'hF, rd, er);
        chk("R2 node 2 untouched", rd, exp_mem[2][4]);
        mon_on = 1'b0;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule